// File: doc/BRIEF.md
# Programmable Interval Timer (single channel)

This block is a single-channel down-counting interval timer. It advances only on cycles where an external one-microsecond tick enable is high, and raises a level interrupt when the count runs out. Software arms it with one write to a control word that carries the enable flag, the auto-reload flag and a terminal count. It can run as a one-shot that disarms itself, or as a periodic source that reloads and fires again and again.

A second register word reports the remaining count and the pending interrupt flag. Writing a one to the clear bit of that word drops the interrupt. Both words sit on a simple register bus. A request is a single-cycle strobe, and read data comes back one cycle after the read strobe with a valid flag.

Top module: `interval_timer`

## Requirements
- R1: After reset the interrupt is low, and both register words (offset 0x0 and offset 0x4) read as zero.
- R2: A write to offset 0x0 stores bit 31 as enable, bit 30 as periodic (auto-reload) and bits 28:0 as the load value. A read of offset 0x0 returns these in the same positions.
- R3: With the timer enabled and load value N-1, the interrupt rises on the Nth tick after the write and not before. The count drops by one per tick.
- R4: A load value of 0 expires on the first tick.
- R5: In one-shot mode (bit 30 = 0), expiry clears the enable bit and leaves the count at 0. Further ticks produce no new expiry.
- R6: In periodic mode (bit 30 = 1), expiry reloads the count with the load value, and the timer fires again every N ticks.
- R7: Writing 0 to offset 0x0 stops the timer: ticks no longer change the count and no interrupt is raised.
- R8: The interrupt is an active-high level. It stays asserted until a write to offset 0x4 with bit 30 set. A write to offset 0x4 with bit 30 clear leaves it unchanged.
- R9: If a clear write and an expiry fall in the same cycle, the interrupt stays asserted.
- R10: A write to offset 0x0 reloads the count at once. A tick in the same cycle as that write is ignored, and counting resumes on the next tick.
- R11: A read of offset 0x4 returns the remaining count in bits 28:0 and the pending interrupt flag in bit 30. All other bits read 0.
- R12: Without a tick the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count enable (1 MHz rate) |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Byte offset (0x0 control, 0x4 status/clear) |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench probes the off-by-one edge of the count. It samples the interrupt after N-1 ticks and after N ticks. A design that expires on the transition to zero fires one tick early, and a design that skips the zero state fires one tick late. It also drives a clear write together with an expiring tick. A design that lets the clear win would lose an interrupt, and the bench sees the line low. A third case puts a control write in the same cycle as a tick. A design that decrements after reloading reads back one below the written value. Periodic reload is checked by reading the status right after expiry, where a missing reload leaves the count at 0. The self-disarm in one-shot mode is checked through the control word, where a design that keeps counting would wrap around and fire again.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Register selector derived from the byte offset bit 2.
  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_STATUS = 1'b1
  } itmr_sel_e;

  // Control word fields decoded by software; positions are fixed.
  localparam int unsigned EN_POS  = 31;
  localparam int unsigned PER_POS = 30;
  // Status word: pending flag and clear strobe share one position.
  localparam int unsigned PND_POS = 30;

  typedef struct packed {
    logic en;
    logic per;
  } itmr_mode_t;

endpackage

// File: rtl/itmr_rst_sync.sv
module itmr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/itmr_regif.sv
module itmr_regif
  import itmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  itmr_mode_t        mode_i,
  input  logic [CNT_W-1:0]  load_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              pend_i,
  output logic              ctrl_wr_o,
  output itmr_mode_t        new_mode_o,
  output logic [CNT_W-1:0]  new_load_o,
  output logic              clr_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);

  itmr_sel_e         sel;
  logic              rd_req;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign sel    = itmr_sel_e'(addr_i[2]);
  assign rd_req = req_i && !we_i;

  // Write decode
  always_comb begin
    ctrl_wr_o      = req_i && we_i && (sel == SEL_CTRL);
    clr_o          = req_i && we_i && (sel == SEL_STATUS) && wdata_i[PND_POS];
    new_mode_o.en  = wdata_i[EN_POS];
    new_mode_o.per = wdata_i[PER_POS];
    new_load_o     = wdata_i[CNT_W-1:0];
  end

  // Read mux (next state)
  always_comb begin
    rdata_d = '0;
    if (sel == SEL_CTRL) begin
      rdata_d[CNT_W-1:0] = load_i;
      rdata_d[EN_POS]    = mode_i.en;
      rdata_d[PER_POS]   = mode_i.per;
    end else begin
      rdata_d[CNT_W-1:0] = cnt_i;
      rdata_d[PND_POS]   = pend_i;
    end
  end

  // Read registers, data held unless a read is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;

  logic unused_addr;
  assign unused_addr = ^{addr_i[1:0], (ADDR_W > 3) ? 1'b0 : 1'b0};

  // R11
  status_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel == SEL_STATUS) |=> (rdata_o[PND_POS] == $past(pend_i)));

  // R11
  status_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && sel == SEL_STATUS) |=> (rdata_o[CNT_W-1:0] == $past(cnt_i)));

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
#(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctrl_wr_i,
  input  itmr_mode_t       new_mode_i,
  input  logic [CNT_W-1:0] new_load_i,
  output itmr_mode_t       mode_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  itmr_mode_t       mode_d, mode_q;
  logic [CNT_W-1:0] load_d, load_q;
  logic [CNT_W-1:0] cnt_d,  cnt_q;
  logic             step;
  logic             at_zero;

  // A control write in the same cycle pre-empts the tick.
  assign step     = tick_i && mode_q.en && !ctrl_wr_i;
  assign at_zero  = (cnt_q == '0);
  assign expire_o = step && at_zero;

  always_comb begin
    mode_d = mode_q;
    load_d = load_q;
    cnt_d  = cnt_q;
    if (ctrl_wr_i) begin
      mode_d = new_mode_i;
      load_d = new_load_i;
      cnt_d  = new_load_i;
    end else if (step) begin
      if (at_zero) begin
        if (mode_q.per) cnt_d = load_q;
        else            mode_d.en = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;
  assign load_o = load_q;
  assign cnt_o  = cnt_q;

  // R3
  dec_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_q.en && !ctrl_wr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R5
  oneshot_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !mode_q.per) |=> (!mode_q.en && cnt_q == '0));

  // R6
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && mode_q.per) |=> (mode_q.en && cnt_q == $past(load_q)));

  // R12
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ctrl_wr_i) |=> $stable(cnt_q));

  // R10
  reload_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (cnt_q == $past(new_load_i)));

endmodule

// File: rtl/itmr_irq.sv
module itmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_d, pend_q;

  // Expiry dominates a simultaneous clear.
  always_comb begin
    pend_d = pend_q;
    if (clr_i)    pend_d = 1'b0;
    if (expire_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R8
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);

  // R9
  expire_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> pend_q);

  // R8
  clear_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !pend_q);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic             rst_n_sync;
  logic             ctrl_wr;
  logic             clr;
  itmr_mode_t       new_mode;
  logic [CNT_W-1:0] new_load;
  itmr_mode_t       mode;
  logic [CNT_W-1:0] load;
  logic [CNT_W-1:0] cnt;
  logic             expire;
  logic             pend;

  itmr_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  itmr_regif #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_regif (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mode_i     (mode),
    .load_i     (load),
    .cnt_i      (cnt),
    .pend_i     (pend),
    .ctrl_wr_o  (ctrl_wr),
    .new_mode_o (new_mode),
    .new_load_o (new_load),
    .clr_o      (clr),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o)
  );

  itmr_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .tick_i     (tick_i),
    .ctrl_wr_i  (ctrl_wr),
    .new_mode_i (new_mode),
    .new_load_i (new_load),
    .mode_o     (mode),
    .load_o     (load),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  itmr_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_sync),
    .expire_i (expire),
    .clr_i    (clr),
    .pend_o   (pend)
  );

  assign irq_o = pend;

  // R7
  stopped_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
    (!mode.en && !ctrl_wr) |=> (!expire && $stable(cnt)));

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        req;
  logic        we;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic        rvalid;
  logic [31:0] rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  interval_timer i_interval_timer (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .req_i    (req),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rvalid_o (rvalid),
    .rdata_o  (rdata),
    .irq_o    (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor: pops expected read data as the design returns it.
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read data actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d; tick = 1'b1;
    @(negedge clk); req = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(3'h0, 32'h0000_0000, "R1");
    rd(3'h4, 32'h0000_0000, "R1");

    // R2 one-shot, N = 5
    wr(3'h0, 32'h8000_0004);
    rd(3'h0, 32'h8000_0004, "R2");
    rd(3'h4, 32'h0000_0004, "R11");
    ticks(4);
    chk_irq(1'b0, "R3 early");
    rd(3'h4, 32'h0000_0000, "R3");
    ticks(1);
    chk_irq(1'b1, "R3");
    rd(3'h0, 32'h0000_0004, "R5");
    rd(3'h4, 32'h4000_0000, "R11");
    idle(6);
    chk_irq(1'b1, "R8 hold");
    wr(3'h4, 32'h0000_0000);
    chk_irq(1'b1, "R8 no-op clear");
    wr(3'h4, 32'h4000_0000);
    chk_irq(1'b0, "R8 clear");
    ticks(3);
    chk_irq(1'b0, "R5 disarmed");
    rd(3'h4, 32'h0000_0000, "R5");

    // R4 zero load
    wr(3'h0, 32'h8000_0000);
    ticks(1);
    chk_irq(1'b1, "R4");
    wr(3'h4, 32'h4000_0000);

    // R6 periodic, N = 3
    wr(3'h0, 32'hC000_0002);
    ticks(3);
    chk_irq(1'b1, "R6 first");
    rd(3'h4, 32'h4000_0002, "R6");
    wr(3'h4, 32'h4000_0000);
    ticks(2);
    chk_irq(1'b0, "R6 mid");
    ticks(1);
    chk_irq(1'b1, "R6 second");
    wr(3'h4, 32'h4000_0000);

    // R7 stop
    wr(3'h0, 32'hC000_0002);
    ticks(1);
    wr(3'h0, 32'h0000_0000);
    ticks(5);
    chk_irq(1'b0, "R7");
    rd(3'h0, 32'h0000_0000, "R7");
    rd(3'h4, 32'h0000_0000, "R7");

    // R12 no tick, no change
    wr(3'h0, 32'h8000_0007);
    idle(10);
    rd(3'h4, 32'h0000_0007, "R12");

    // R10 reload on write, same-cycle tick ignored
    ticks(3);
    rd(3'h4, 32'h0000_0004, "R3");
    wr(3'h0, 32'h8000_0009);
    rd(3'h4, 32'h0000_0009, "R10");
    wr_tick(3'h0, 32'h8000_0005);
    rd(3'h4, 32'h0000_0005, "R10");
    ticks(1);
    rd(3'h4, 32'h0000_0004, "R10");

    // R9 clear and expiry together
    wr(3'h0, 32'h8000_0000);
    ticks(1);
    chk_irq(1'b1, "R9 setup");
    wr(3'h0, 32'h8000_0000);
    wr_tick(3'h4, 32'h4000_0000);
    chk_irq(1'b1, "R9");
    rd(3'h4, 32'h4000_0000, "R9");
    wr(3'h4, 32'h4000_0000);
    chk_irq(1'b0, "R9 after clear");

    idle(4);
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL reads missing actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule